// File: doc/BRIEF.md
# Blinking Text Cursor Overlay

This block places a text cursor on the character stream of a character-cell display controller. For every character byte the fetch logic presents, it compares the byte's memory address and raster row against a programmed cursor position and a band of raster lines. When they match and the cursor is currently visible, it returns the byte with every bit inverted. In all other cases the byte passes through unchanged. The output path is purely combinational, so the overlay adds no latency to the fetch pipeline.

Visibility is set by three mode inputs: cursor enable, blink enable and blink rate. A graphics-mode input turns the cursor off. With blinking active, a frame counter advances on a per-frame strobe. Each time it reaches the selected limit, it flips the visible phase. The cursor position is given as two byte-wide halves that are joined into a single memory address.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, the blink phase is hidden and the frame counter is zero. With cursor and blink both enabled straight after reset, `cursor_shown` is 0 and no byte is inverted.
- R2: While `cur_enable` is 0, `cursor_shown` is 0 and `out_data` equals `fetch_data` for every address and row.
- R3: With `cur_enable` 1, `blink_enable` 0 and `gfx_mode` 0, `cursor_shown` is 1 regardless of frame strobes, and a matching fetch has all data bits inverted (`out_data = ~fetch_data`).
- R4: The cursor address is `{cur_addr_hi, cur_addr_lo}`, with the high byte in address bits 15:8. A fetch whose address differs in either byte is not inverted.
- R5: The row band includes both ends. Rows equal to `band_top` or `band_bottom` are inverted, and rows outside the band are not.
- R6: When `band_top` is greater than `band_bottom`, no row matches and nothing is inverted.
- R7: With `blink_fast` 1, a frame strobe that finds the counter at 16 or more flips the phase and zeroes the counter. Starting from zero, the phase therefore flips on every 17th strobe.
- R8: With `blink_fast` 0, the limit is 32, so the phase flips on every 33rd strobe counted from zero.
- R9: The counter and phase change only on a cycle with `frame_tick` high while cursor and blink are both enabled outside graphics mode. With blink disabled, the counter keeps its value and resumes from it later.
- R10: While `gfx_mode` is 1, `cursor_shown` is 0, no byte is inverted, and on each clock the counter and phase are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gfx_mode | input | 1 | Graphics mode: suppresses cursor, clears blink state |
| cur_enable | input | 1 | Cursor enable |
| blink_enable | input | 1 | Blink enable |
| blink_fast | input | 1 | 1 selects the 16-frame limit, 0 the 32-frame limit |
| cur_addr_hi | input | 8 | Cursor address, upper byte |
| cur_addr_lo | input | 8 | Cursor address, lower byte |
| band_top | input | 4 | First raster row of the cursor band |
| band_bottom | input | 4 | Last raster row of the cursor band |
| frame_tick | input | 1 | One-cycle pulse per frame |
| fetch_addr | input | 16 | Memory address of the current character byte |
| fetch_row | input | 4 | Raster row within the character cell |
| fetch_data | input | 8 | Fetched character byte |
| out_data | output | 8 | Character byte, inverted under the visible cursor |
| cursor_shown | output | 1 | Current cursor visibility |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 16-bit address, 4-bit rows, and limits of 16 and 32 frames. These limits are small enough that the bench can drive whole blink periods strobe by strobe. It checks the exact strobe on which the phase flips at both rates. It also checks that a count held while blinking is off resumes from where it stopped, and that graphics mode clears a half-finished count. A 4-bit row lets the bench probe both edges of the band, a reversed band and a single-row band.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int ROW_W       = 4,
  parameter int FAST_FRAMES = 16,
  parameter int SLOW_FRAMES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gfx_mode,
  input  logic                  cur_enable,
  input  logic                  blink_enable,
  input  logic                  blink_fast,
  input  logic [ADDR_W/2-1:0]   cur_addr_hi,
  input  logic [ADDR_W/2-1:0]   cur_addr_lo,
  input  logic [ROW_W-1:0]      band_top,
  input  logic [ROW_W-1:0]      band_bottom,
  input  logic                  frame_tick,
  input  logic [ADDR_W-1:0]     fetch_addr,
  input  logic [ROW_W-1:0]      fetch_row,
  input  logic [DATA_W-1:0]     fetch_data,
  output logic [DATA_W-1:0]     out_data,
  output logic                  cursor_shown
);
  localparam int CW = $clog2(SLOW_FRAMES + 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_FRAMES);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_FRAMES);

  logic [CW-1:0] frame_cnt;
  logic          phase;
  logic [CW-1:0] limit;
  logic          blinking;
  logic          addr_hit;
  logic          row_hit;
  logic          invert;

  assign blinking = cur_enable & blink_enable & ~gfx_mode;
  assign limit    = blink_fast ? FAST_LIM : SLOW_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n || gfx_mode) begin
      frame_cnt <= '0;
      phase     <= 1'b0;
    end else if (frame_tick && blinking) begin
      if (frame_cnt >= limit) begin
        frame_cnt <= '0;
        phase     <= ~phase;
      end else begin
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  assign cursor_shown = ~gfx_mode & cur_enable & (~blink_enable | phase);
  assign addr_hit     = (fetch_addr == {cur_addr_hi, cur_addr_lo});
  assign row_hit      = (fetch_row >= band_top) && (fetch_row <= band_bottom);
  assign invert       = cursor_shown & addr_hit & row_hit;
  assign out_data     = fetch_data ^ {DATA_W{invert}};

  // R2: a disabled cursor never touches the data
  a_r2_off_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_enable |-> (out_data == fetch_data && !cursor_shown));

  // R6: a reversed band matches no row
  a_r6_empty_band: assert property (@(posedge clk) disable iff (!rst_n)
    (band_top > band_bottom) |-> (out_data == fetch_data));

  // R7/R8: the counter stays within the slow limit
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= SLOW_LIM);

  // R9: blink state only moves on a frame strobe
  a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !gfx_mode) |=> ($stable(frame_cnt) && $stable(phase)));

  // R10: graphics mode clears the blink state
  a_r10_gfx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_mode |=> (frame_cnt == '0 && !phase));

  a_r10_gfx_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_mode |-> (!cursor_shown && out_data == fetch_data));
endmodule

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gfx_mode = 1'b0, cur_enable = 1'b0, blink_enable = 1'b0, blink_fast = 1'b0;
  logic [7:0] cur_addr_hi = 8'h00, cur_addr_lo = 8'h00;
  logic [3:0] band_top = 4'd0, band_bottom = 4'd0;
  logic frame_tick = 1'b0;
  logic [15:0] fetch_addr = 16'h0;
  logic [3:0] fetch_row = 4'd0;
  logic [7:0] fetch_data = 8'h00;
  logic [7:0] out_data;
  logic cursor_shown;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cursor_overlay u_dut (
    .clk(clk), .rst_n(rst_n), .gfx_mode(gfx_mode), .cur_enable(cur_enable),
    .blink_enable(blink_enable), .blink_fast(blink_fast),
    .cur_addr_hi(cur_addr_hi), .cur_addr_lo(cur_addr_lo),
    .band_top(band_top), .band_bottom(band_bottom), .frame_tick(frame_tick),
    .fetch_addr(fetch_addr), .fetch_row(fetch_row), .fetch_data(fetch_data),
    .out_data(out_data), .cursor_shown(cursor_shown));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
    end
    #1;
  endtask

  task automatic probe(input logic [15:0] a, input logic [3:0] r, input logic [7:0] d);
    @(negedge clk); fetch_addr = a; fetch_row = r; fetch_data = d; #1;
  endtask

  task automatic t_reset();
    do_reset();
    cur_enable = 1'b1; blink_enable = 1'b1; blink_fast = 1'b1;
    cur_addr_hi = 8'h12; cur_addr_lo = 8'h34; band_top = 4'd0; band_bottom = 4'd15;
    probe(16'h1234, 4'd3, 8'hA5);
    check("R1 shown", cursor_shown, 0);
    check("R1 data", out_data, 8'hA5);
  endtask

  task automatic t_off();
    do_reset();
    cur_enable = 1'b0; blink_enable = 1'b0;
    ticks(3);
    probe(16'h1234, 4'd3, 8'h3C);
    check("R2 shown", cursor_shown, 0);
    check("R2 data", out_data, 8'h3C);
  endtask

  task automatic t_steady();
    do_reset();
    cur_enable = 1'b1; blink_enable = 1'b0;
    band_top = 4'd2; band_bottom = 4'd5;
    ticks(40);
    probe(16'h1234, 4'd3, 8'hA5);
    check("R3 shown", cursor_shown, 1);
    check("R3 invert", out_data, 8'h5A);
    probe(16'h1334, 4'd3, 8'hA5); check("R4 hi mismatch", out_data, 8'hA5);
    probe(16'h1235, 4'd3, 8'hA5); check("R4 lo mismatch", out_data, 8'hA5);
    probe(16'h1234, 4'd2, 8'h0F); check("R5 top row", out_data, 8'hF0);
    probe(16'h1234, 4'd5, 8'h0F); check("R5 bottom row", out_data, 8'hF0);
    probe(16'h1234, 4'd1, 8'h0F); check("R5 above band", out_data, 8'h0F);
    probe(16'h1234, 4'd6, 8'h0F); check("R5 below band", out_data, 8'h0F);
    band_top = 4'd6; band_bottom = 4'd2;
    probe(16'h1234, 4'd3, 8'h0F); check("R6 reversed", out_data, 8'h0F);
    probe(16'h1234, 4'd6, 8'h0F); check("R6 reversed edge", out_data, 8'h0F);
    band_top = 4'd4; band_bottom = 4'd4;
    probe(16'h1234, 4'd4, 8'h81); check("R5 single row", out_data, 8'h7E);
  endtask

  task automatic t_fast();
    do_reset();
    cur_enable = 1'b1; blink_enable = 1'b1; blink_fast = 1'b1;
    band_top = 4'd0; band_bottom = 4'd15;
    ticks(16); check("R7 before flip", cursor_shown, 0);
    ticks(1);  check("R7 flip on", cursor_shown, 1);
    probe(16'h1234, 4'd0, 8'h00); check("R7 inverted while on", out_data, 8'hFF);
    ticks(16); check("R7 hold on", cursor_shown, 1);
    ticks(1);  check("R7 flip off", cursor_shown, 0);
  endtask

  task automatic t_slow();
    do_reset();
    cur_enable = 1'b1; blink_enable = 1'b1; blink_fast = 1'b0;
    ticks(32); check("R8 before flip", cursor_shown, 0);
    ticks(1);  check("R8 flip on", cursor_shown, 1);
  endtask

  task automatic t_hold();
    do_reset();
    cur_enable = 1'b1; blink_enable = 1'b1; blink_fast = 1'b1;
    ticks(10);
    blink_enable = 1'b0;
    ticks(20); check("R9 steady while paused", cursor_shown, 1);
    blink_enable = 1'b1;
    ticks(6); check("R9 resumed count", cursor_shown, 0);
    ticks(1); check("R9 flip at resumed count", cursor_shown, 1);
  endtask

  task automatic t_gfx();
    do_reset();
    cur_enable = 1'b1; blink_enable = 1'b1; blink_fast = 1'b1;
    ticks(17); check("R10 phase set", cursor_shown, 1);
    ticks(10);
    @(negedge clk); gfx_mode = 1'b1;
    probe(16'h1234, 4'd0, 8'h55);
    check("R10 hidden", cursor_shown, 0);
    check("R10 data", out_data, 8'h55);
    ticks(5);
    @(negedge clk); gfx_mode = 1'b0; #1;
    check("R10 phase cleared", cursor_shown, 0);
    ticks(16); check("R10 count cleared", cursor_shown, 0);
    ticks(1);  check("R10 fresh flip", cursor_shown, 1);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_off();
    t_steady();
    t_fast();
    t_slow();
    t_hold();
    t_gfx();
    finish_up();
  end
endmodule